// File: doc/BRIEF.md
# Branch History and Target Table

This block is a direct-mapped table that sits beside the fetch stage of a five-stage pipeline. Each of its slots carries a valid flag, a saved branch target address and a short history of the outcomes of the branch that last used that slot. The fetch stage presents its current PC on a lookup port and receives, in the same cycle, whether the slot is live, whether the branch there is predicted taken, and the target to fetch next. When a miss is reported, the consumer keeps the not-taken path.

Once a branch resolves later in the pipeline, the update port writes the real outcome and the computed target into the slot selected by that branch's PC. A slot that holds no valid contents is seeded from this first outcome, as strongly taken or strongly not-taken. A live slot instead has its history stepped and its target replaced. A build-time parameter selects the history kind: a single bit that follows the latest outcome, or a two-bit saturating counter. Slots carry no tags, so branches whose PCs share the index bits share a slot.

Top module: `branch_target_table`

## Requirements
- R1: A synchronous reset, `rst` high at a rising clock edge, marks every slot invalid, so every lookup after it misses until that slot is written again.
- R2: On a miss (`lk_hit` = 0), `lk_taken` is 0 and `lk_target` is all zeros.
- R3: The slot is selected by the low five PC bits, `pc[4:0]`, on both ports. The upper PC bits play no part in the selection.
- R4: In two-bit mode (`TWO_BIT` = 1), a write to an invalid slot sets its counter to binary 11 when the outcome is taken and to 00 when it is not taken, and makes the slot valid.
- R5: In two-bit mode, a write to a valid slot moves the counter up by one on taken and down by one on not-taken. The counter stops at 11 and at 00, and `lk_taken` equals the counter's upper bit.
- R6: In one-bit mode (`TWO_BIT` = 0), every write sets the predicted direction to the outcome just written, whatever it was before.
- R7: Each write stores `up_target` as the slot's target, whether the slot was valid or not. A later lookup of that slot returns the stored target.
- R8: A write takes effect at the rising clock edge. A lookup of the slot being written in that same cycle returns the contents from before the write.
- R9: Two branches whose PCs differ only above bit 4 use the same slot, so a write by either one is seen by lookups of both.
- R10: While `up_en` is 0, no slot changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | 32 | Fetch-stage PC used for lookup |
| lk_hit | output | 1 | Selected slot is valid |
| lk_taken | output | 1 | Predict taken (0 on miss) |
| lk_target | output | 32 | Predicted target (0 on miss) |
| up_en | input | 1 | Write the outcome of a resolved branch |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_target | input | 32 | Computed branch target |

## Verification
The bench builds two copies side by side under one stimulus: one with `TWO_BIT` = 1 and one with `TWO_BIT` = 0. With both history kinds fed the same outcome stream, every lookup compares the counter walk (seeding, climbing to 11, falling to 00, and holding at each end) against the single bit that flips on every change. The remaining width, entry and PC parameters stay at their defaults. Slot 31, slot 0 and PCs that differ only above bit 4 are therefore all reachable with a handful of 32-bit addresses.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef logic [1:0] hist_t;

    localparam hist_t HIST_STRONG_T = 2'b11;
    localparam hist_t HIST_STRONG_N = 2'b00;

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 5
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // Direct-mapped: the low bits of the PC choose the slot, no tag kept.
    assign idx = pc[IDX_W-1:0];

endmodule

// File: rtl/bht_hist_next.sv
module bht_hist_next
    import bht_pkg::*;
#(
    parameter bit TWO_BIT = 1'b1
) (
    input  logic  cur_vld,
    input  hist_t cur_hist,
    input  logic  taken,
    output hist_t nxt_hist
);
    generate
        if (TWO_BIT) begin : g_two
            always_comb begin
                if (!cur_vld) begin
                    nxt_hist = taken ? HIST_STRONG_T : HIST_STRONG_N;
                end else if (taken) begin
                    nxt_hist = (cur_hist == HIST_STRONG_T) ? cur_hist : cur_hist + 2'd1;
                end else begin
                    nxt_hist = (cur_hist == HIST_STRONG_N) ? cur_hist : cur_hist - 2'd1;
                end
            end
        end else begin : g_one
            // Single bit of history, mirrored into both bits so bit 1 predicts.
            always_comb begin
                nxt_hist = {taken, taken};
            end
        end
    endgenerate

endmodule

// File: rtl/bht_store.sv
module bht_store
    import bht_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int TGT_W   = 32,
    parameter bit TWO_BIT = 1'b1,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output hist_t            rd_hist,
    output logic [TGT_W-1:0] rd_tgt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    input  logic [TGT_W-1:0] wr_tgt
);
    typedef struct packed {
        logic             vld;
        hist_t            hist;
        logic [TGT_W-1:0] tgt;
    } slot_t;

    slot_t [ENTRIES-1:0] tab_d, tab_q;
    slot_t               wr_old;
    hist_t               wr_hist;

    assign wr_old = tab_q[wr_idx];

    bht_hist_next #(.TWO_BIT(TWO_BIT)) u_hist (
        .cur_vld  (wr_old.vld),
        .cur_hist (wr_old.hist),
        .taken    (wr_taken),
        .nxt_hist (wr_hist)
    );

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d[wr_idx].vld  = 1'b1;
            tab_d[wr_idx].hist = wr_hist;
            tab_d[wr_idx].tgt  = wr_tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    // Read sees registered contents only: a same-cycle write is not visible.
    assign rd_vld  = tab_q[rd_idx].vld;
    assign rd_hist = tab_q[rd_idx].hist;
    assign rd_tgt  = tab_q[rd_idx].tgt;

    logic [ENTRIES-1:0] vld_vec;
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) vld_vec[i] = tab_q[i].vld;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> (vld_vec == '0));

    assert_write_sets_valid_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> tab_q[$past(wr_idx)].vld);

    assert_sat_high_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && wr_old.vld && wr_old.hist == HIST_STRONG_T)
        |=> tab_q[$past(wr_idx)].hist == HIST_STRONG_T);

    assert_sat_low_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && wr_old.vld && wr_old.hist == HIST_STRONG_N)
        |=> tab_q[$past(wr_idx)].hist == HIST_STRONG_N);

    assert_target_stored_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> tab_q[$past(wr_idx)].tgt == $past(wr_tgt));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !$past(rst)) |=> $stable(tab_q));

endmodule

// File: rtl/branch_target_table.sv
module branch_target_table #(
    parameter int ENTRIES = 32,
    parameter int PC_W    = 32,
    parameter int TGT_W   = 32,
    parameter bit TWO_BIT = 1'b1,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic             lk_taken,
    output logic [TGT_W-1:0] lk_target,
    input  logic             up_en,
    input  logic [PC_W-1:0]  up_pc,
    input  logic             up_taken,
    input  logic [TGT_W-1:0] up_target
);
    import bht_pkg::*;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             rd_vld;
    hist_t            rd_hist;
    logic [TGT_W-1:0] rd_tgt;

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_rd_idx (.pc(lk_pc), .idx(rd_idx));
    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_wr_idx (.pc(up_pc), .idx(wr_idx));

    bht_store #(.ENTRIES(ENTRIES), .TGT_W(TGT_W), .TWO_BIT(TWO_BIT)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_vld   (rd_vld),
        .rd_hist  (rd_hist),
        .rd_tgt   (rd_tgt),
        .wr_en    (up_en),
        .wr_idx   (wr_idx),
        .wr_taken (up_taken),
        .wr_tgt   (up_target)
    );

    always_comb begin
        lk_hit    = rd_vld;
        lk_taken  = rd_vld & rd_hist[1];
        lk_target = rd_vld ? rd_tgt : '0;
    end

    assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (!lk_taken && lk_target == '0));

endmodule

// File: tb/tb_branch_target_table.sv
module tb_branch_target_table;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_pc = '0;
    logic        up_en = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [31:0] up_target = '0;

    logic        hit2, tk2, hit1, tk1;
    logic [31:0] tg2, tg1;

    always #2 clk = ~clk;  // 250 MHz

    branch_target_table #(.TWO_BIT(1'b1)) dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc),
        .lk_hit(hit2), .lk_taken(tk2), .lk_target(tg2),
        .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target));

    branch_target_table #(.TWO_BIT(1'b0)) dut1 (
        .clk(clk), .rst(rst), .lk_pc(lk_pc),
        .lk_hit(hit1), .lk_taken(tk1), .lk_target(tg1),
        .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target));

    typedef struct {
        logic        hit;
        logic        tk2;
        logic        tk1;
        logic [31:0] tgt;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // Reference model
    logic        m_vld [32];
    logic [1:0]  m_c2  [32];
    logic        m_b1  [32];
    logic [31:0] m_tgt [32];

    task automatic model_clear();
        for (int i = 0; i < 32; i++) m_vld[i] = 1'b0;
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected lookup pushed, model updated.
    task automatic step(input logic en, input logic [31:0] upc, input logic utk,
                        input logic [31:0] utg, input logic [31:0] lpc, input string tag);
        exp_t e;
        int   li, wi;
        @(posedge clk);
        #1;
        up_en = en; up_pc = upc; up_taken = utk; up_target = utg; lk_pc = lpc;
        li = int'(lpc[4:0]);
        e.hit = m_vld[li];
        e.tk2 = m_vld[li] & m_c2[li][1];
        e.tk1 = m_vld[li] & m_b1[li];
        e.tgt = m_vld[li] ? m_tgt[li] : 32'h0;
        e.tag = tag;
        q.push_back(e);
        if (en) begin
            wi = int'(upc[4:0]);
            if (!m_vld[wi]) m_c2[wi] = utk ? 2'b11 : 2'b00;
            else if (utk && m_c2[wi] != 2'b11) m_c2[wi] = m_c2[wi] + 2'd1;
            else if (!utk && m_c2[wi] != 2'b00) m_c2[wi] = m_c2[wi] - 2'd1;
            m_b1[wi]  = utk;
            m_tgt[wi] = utg;
            m_vld[wi] = 1'b1;
        end
    endtask

    task automatic look(input logic [31:0] lpc, input string tag);
        step(1'b0, 32'h0, 1'b0, 32'h0, lpc, tag);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1; up_en = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
        model_clear();
    endtask

    // Monitor: compares both builds against the popped expectation.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(e.tag, "hit2",  {31'b0, hit2}, {31'b0, e.hit});
                chk(e.tag, "taken2", {31'b0, tk2}, {31'b0, e.tk2});
                chk(e.tag, "tgt2",  tg2, e.tgt);
                chk(e.tag, "hit1",  {31'b0, hit1}, {31'b0, e.hit});
                chk(e.tag, "taken1", {31'b0, tk1}, {31'b0, e.tk1});
                chk(e.tag, "tgt1",  tg1, e.tgt);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 / R2: all slots miss after reset
        look(32'h0000_0000, "R1");
        look(32'h0000_0007, "R2");
        look(32'h0000_001F, "R1");

        // R8: same-cycle read of a slot being written sees old (miss)
        step(1'b1, 32'h0000_0103, 1'b1, 32'hAAAA_0000, 32'h0000_0003, "R8");
        // R4 seed taken, R3 upper PC bits ignored
        look(32'h0000_0003, "R4");
        look(32'hFFFF_FFE3, "R3");

        // R5/R6 walk down with not-taken, new targets (R7)
        step(1'b1, 32'h0000_0003, 1'b0, 32'hBBBB_0000, 32'h0000_0003, "R8");
        look(32'h0000_0003, "R5");
        step(1'b1, 32'h0000_0003, 1'b0, 32'hBBBB_0004, 32'h0000_0000, "R7");
        look(32'h0000_0003, "R6");
        step(1'b1, 32'h0000_0003, 1'b0, 32'hBBBB_0008, 32'h0000_0000, "R5");
        look(32'h0000_0003, "R5");
        step(1'b1, 32'h0000_0003, 1'b0, 32'hBBBB_000C, 32'h0000_0000, "R5");
        look(32'h0000_0003, "R5");
        // walk up with taken, saturate high
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 32'h0000_0003, 1'b1, 32'hCCCC_0000 + k, 32'h0000_0000, "R5");
            look(32'h0000_0003, "R5");
        end
        // R6 alternating outcomes
        step(1'b1, 32'h0000_0003, 1'b0, 32'hDDDD_0000, 32'h0000_0000, "R6");
        look(32'h0000_0003, "R6");
        step(1'b1, 32'h0000_0003, 1'b1, 32'hDDDD_0004, 32'h0000_0000, "R6");
        look(32'h0000_0003, "R6");

        // R4 seed not-taken in slot 9, slot 31 boundary seed taken
        step(1'b1, 32'h0000_0009, 1'b0, 32'h1234_5678, 32'h0000_0000, "R4");
        look(32'h0000_0009, "R4");
        step(1'b1, 32'h8000_001F, 1'b1, 32'h0F0F_0F0F, 32'h0000_0000, "R4");
        look(32'h0000_001F, "R3");

        // R9: aliasing branch overwrites slot 9
        step(1'b1, 32'h4000_0029, 1'b1, 32'h5555_5555, 32'h0000_0009, "R9");
        look(32'h0000_0009, "R9");
        look(32'h7777_7769, "R9");

        // R10: update fields active but enable low
        step(1'b0, 32'h0000_0009, 1'b0, 32'hDEAD_BEEF, 32'h0000_0009, "R10");
        look(32'h0000_0009, "R10");
        step(1'b0, 32'h0000_000A, 1'b1, 32'hDEAD_BEEF, 32'h0000_000A, "R10");
        look(32'h0000_000A, "R10");

        // R1: reset after use clears populated slots
        do_reset();
        look(32'h0000_0003, "R1");
        look(32'h0000_0009, "R1");
        look(32'h0000_001F, "R2");
        // re-seed after reset follows first outcome
        step(1'b1, 32'h0000_0003, 1'b0, 32'h0000_1000, 32'h0000_0000, "R4");
        look(32'h0000_0003, "R4");

        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule